// File: doc/BRIEF.md
# Two-Line Up/Down Step Counter

This block turns activity on two slow input lines into up and down steps of a wrapping counter. It runs in two families of decoding. In step-and-direction operation, line A sets the counting direction and line B carries the count edges. In split-clock operation, line A is an up-count clock, line B is a down-count clock, and only one of them is expected to pulse at a time. Each family has a double-edge variant and a single-edge variant. A 4-bit mode field picks the family and the variant. Two per-line polarity bits select the direction sense, the idle level and the active edge.

Both lines pass through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. The counter runs from zero up to a programmable reload value and back. Every wrap raises a one-cycle update pulse. A status bit reports the direction of the latest step.

The mode and polarity settings are captured only while the enable input is low. A control state machine chooses the decoding state. Its states are `ST_CFG` (configuring, counter frozen), `ST_SDIR_X2`, `ST_SDIR_X1`, `ST_SPLIT_X2`, `ST_SPLIT_X1` (the four counting states) and `ST_STALL` (undefined mode, counter frozen). Its transitions are named as follows:
- `T_START`: from `ST_CFG` on a high enable, into the state picked by the captured mode.
- `T_STOP`: from any other state back to `ST_CFG` on a low enable.
- `T_HOLD`: stay in the current state otherwise.

Top module: `enc_counter`

## Requirements
- R1: While reset is asserted, and right after it, `count` is 0, `dir_down` is 0 and `update` is 0.
- R2: Mode 4'b1100 (split clock, double edge) counts up by one on every rising or falling edge of line A and down by one on every edge of line B, whatever the polarity bits.
- R3: Mode 4'b1101 (split clock, single edge) counts on one edge per line. Polarity bit 0 means falling edges only, with the line idling high. Polarity bit 1 means rising edges only, with the line idling low. Edges of the other sense leave the counter unchanged.
- R4: Mode 4'b1010 (step and direction, double edge) steps on both edges of line B. With `pol_a`=0 the step is up while line A is high and down while it is low.
- R5: Mode 4'b1011 (step and direction, single edge) steps on one edge of line B only. That edge is rising when `pol_b`=1 and falling when `pol_b`=0.
- R6: In step-and-direction modes, `pol_a`=1 inverts the direction sense, so line A high gives down steps.
- R7: In split-clock modes, an edge on both lines in the same cycle leaves the counter unchanged.
- R8: An up step from a count equal to or above `reload_val` gives 0 and a one-cycle `update` pulse.
- R9: A down step from 0 gives `reload_val` and a one-cycle `update` pulse.
- R10: `dir_down` is 0 after an up step and 1 after a down step. It changes in the same cycle as `count` and keeps its value when no step occurs.
- R11: `mode`, `pol_a` and `pol_b` are captured only while `en` is low. Changing them while `en` is high has no effect on counting.
- R12: A mode value other than the four defined ones leaves the counter frozen while enabled.
- R13: While `en` is low the counter holds its value.
- R14: An input change shows up on `count` three clock edges after it is applied: two synchronizer stages, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable; settings are captured while low |
| mode | input | 4 | Decoding mode field |
| pol_a | input | 1 | Line A polarity bit |
| pol_b | input | 1 | Line B polarity bit |
| line_a | input | 1 | Input line A (direction or up clock) |
| line_b | input | 1 | Input line B (step clock or down clock) |
| reload_val | input | 16 | Auto-reload (top) value |
| count | output | 16 | Counter value |
| dir_down | output | 1 | 1 when the latest step was down |
| update | output | 1 | One-cycle pulse on each wrap |

## Verification
Directed scenarios drive single-line pulses in each of the four modes. Each scenario flips the polarity bits, which separates edge selection from idle-level coding: the same pulse counts twice, once, or not at all depending on the mode. Step-and-direction runs toggle line B under both levels of line A and both values of `pol_a`, which separates the direction sense from the edge sense. Wrap runs cross the reload value in both directions while counting update pulses. The remaining runs cover coincident edges on both lines, a mode change while enabled, an undefined mode and a low enable, and each must leave the counter unchanged.

// File: rtl/enc_pkg.sv
package enc_pkg;

    localparam logic [3:0] MODE_SDIR_X2  = 4'b1010;
    localparam logic [3:0] MODE_SDIR_X1  = 4'b1011;
    localparam logic [3:0] MODE_SPLIT_X2 = 4'b1100;
    localparam logic [3:0] MODE_SPLIT_X1 = 4'b1101;

    typedef enum logic [2:0] {
        ST_CFG      = 3'd0,
        ST_SDIR_X2  = 3'd1,
        ST_SDIR_X1  = 3'd2,
        ST_SPLIT_X2 = 3'd3,
        ST_SPLIT_X1 = 3'd4,
        ST_STALL    = 3'd5
    } enc_state_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_evt_t;

endpackage

// File: rtl/enc_line_sync.sv
module enc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din,
    output enc_pkg::line_evt_t evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // synchronizer chain
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // previous synchronized sample for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    always_comb begin
        evt.lvl  = sync_q[STAGES-1];
        evt.rise = sync_q[STAGES-1] & ~prev_q;
        evt.fall = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/enc_step_decode.sv
module enc_step_decode (
    input  enc_pkg::enc_state_t state,
    input  logic                pol_a,
    input  logic                pol_b,
    input  enc_pkg::line_evt_t  ev_a,
    input  enc_pkg::line_evt_t  ev_b,
    output logic                step_up,
    output logic                step_dn
);
    import enc_pkg::*;

    logic a_any, b_any, a_sel, b_sel, sdir_up;

    always_comb begin
        a_any   = ev_a.rise | ev_a.fall;
        b_any   = ev_b.rise | ev_b.fall;
        // single-edge pick: polarity 1 -> rising, 0 -> falling
        a_sel   = pol_a ? ev_a.rise : ev_a.fall;
        b_sel   = pol_b ? ev_b.rise : ev_b.fall;
        sdir_up = ev_a.lvl ^ pol_a;
    end

    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (state)
            ST_SDIR_X2: begin
                step_up = b_any & sdir_up;
                step_dn = b_any & ~sdir_up;
            end
            ST_SDIR_X1: begin
                step_up = b_sel & sdir_up;
                step_dn = b_sel & ~sdir_up;
            end
            ST_SPLIT_X2: begin
                step_up = a_any & ~b_any;
                step_dn = b_any & ~a_any;
            end
            ST_SPLIT_X1: begin
                step_up = a_sel & ~b_sel;
                step_dn = b_sel & ~a_sel;
            end
            ST_CFG, ST_STALL: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
            default: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/enc_count_core.sv
module enc_count_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [WIDTH-1:0] reload_val,
    output logic [WIDTH-1:0] count,
    output logic             dir_down,
    output logic             update
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q, cnt_d;
    logic             dir_q, dir_d, upd_q, upd_d;

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        upd_d = 1'b0;
        if (step_up) begin
            dir_d = 1'b0;
            if (cnt_q >= reload_val) begin
                cnt_d = ZERO;
                upd_d = 1'b1;
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end else if (step_dn) begin
            dir_d = 1'b1;
            if (cnt_q == ZERO) begin
                cnt_d = reload_val;
                upd_d = 1'b1;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dir_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
            upd_q <= upd_d;
        end
    end

    assign count    = cnt_q;
    assign dir_down = dir_q;
    assign update   = upd_q;
endmodule

// File: rtl/enc_counter.sv
module enc_counter #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [3:0]       mode,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic             line_a,
    input  logic             line_b,
    input  logic [WIDTH-1:0] reload_val,
    output logic [WIDTH-1:0] count,
    output logic             dir_down,
    output logic             update
);
    import enc_pkg::*;

    localparam int NLINES = 2;

    enc_state_t state_q, state_d;
    logic [3:0] cfg_mode_q;
    logic       cfg_pol_a_q, cfg_pol_b_q;
    logic       step_up, step_dn;
    line_evt_t  ev_a, ev_b;
    line_evt_t  ev [NLINES];
    logic [NLINES-1:0] lines_in;

    assign lines_in = {line_b, line_a};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        enc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (lines_in[g]),
            .evt  (ev[g])
        );
    end

    assign ev_a = ev[0];
    assign ev_b = ev[1];

    // settings captured only while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mode_q  <= 4'b0000;
            cfg_pol_a_q <= 1'b0;
            cfg_pol_b_q <= 1'b0;
        end else if (!en) begin
            cfg_mode_q  <= mode;
            cfg_pol_a_q <= pol_a;
            cfg_pol_b_q <= pol_b;
        end
    end

    // next-state logic: T_START / T_STOP / T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG: begin
                if (en) begin
                    unique case (cfg_mode_q)
                        MODE_SDIR_X2:  state_d = ST_SDIR_X2;
                        MODE_SDIR_X1:  state_d = ST_SDIR_X1;
                        MODE_SPLIT_X2: state_d = ST_SPLIT_X2;
                        MODE_SPLIT_X1: state_d = ST_SPLIT_X1;
                        default:       state_d = ST_STALL;
                    endcase
                end
            end
            ST_SDIR_X2, ST_SDIR_X1, ST_SPLIT_X2, ST_SPLIT_X1, ST_STALL: begin
                if (!en) state_d = ST_CFG;
            end
            default: state_d = ST_CFG;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CFG;
        else        state_q <= state_d;
    end

    // outputs of the state machine: step requests
    enc_step_decode u_decode (
        .state  (state_q),
        .pol_a  (cfg_pol_a_q),
        .pol_b  (cfg_pol_b_q),
        .ev_a   (ev_a),
        .ev_b   (ev_b),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    enc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .reload_val(reload_val),
        .count     (count),
        .dir_down  (dir_down),
        .update    (update)
    );
endmodule

// File: rtl/enc_counter_chk.sv
module enc_counter_chk #(
    parameter int WIDTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  enc_pkg::enc_state_t state,
    input  enc_pkg::line_evt_t  ev_a,
    input  enc_pkg::line_evt_t  ev_b,
    input  logic [WIDTH-1:0]    count,
    input  logic [WIDTH-1:0]    reload_val,
    input  logic                dir_down,
    input  logic                update
);
    import enc_pkg::*;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !update && !dir_down));

    a_r13_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG) |=> $stable(count));

    a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |=> $stable(count));

    a_r7_coincident_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SPLIT_X2) && (ev_a.rise || ev_a.fall) && (ev_b.rise || ev_b.fall))
        |=> $stable(count));

    a_r8_update_value: assert property (@(posedge clk) disable iff (!rst_n)
        update |-> (count == '0 || count == reload_val));

    a_r10_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !update && count == WIDTH'($past(count) + 1'b1)) |-> !dir_down);

    a_r10_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !update && count == WIDTH'($past(count) - 1'b1)) |-> dir_down);
endmodule

bind enc_counter enc_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .ev_a      (ev_a),
    .ev_b      (ev_b),
    .count     (count),
    .reload_val(reload_val),
    .dir_down  (dir_down),
    .update    (update)
);

// File: tb/tb_enc_counter.sv
`timescale 1ns/1ps
module tb_enc_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        pol_a = 1'b0, pol_b = 1'b0;
    logic        line_a = 1'b0, line_b = 1'b0;
    logic [15:0] reload_val = 16'd20;
    logic [15:0] count;
    logic        dir_down, update;

    int n_checks = 0, n_fail = 0, upd_seen = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    enc_counter dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .pol_a(pol_a), .pol_b(pol_b), .line_a(line_a), .line_b(line_b),
        .reload_val(reload_val), .count(count), .dir_down(dir_down), .update(update)
    );

    always @(negedge clk) if (rst_n && update) upd_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R14: three edges of latency, sample on the negedge after the fourth
    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_step(input int d);
        if (d > 0) exp_cnt = (exp_cnt >= reload_val) ? 0 : exp_cnt + 1;
        else if (d < 0) exp_cnt = (exp_cnt == 0) ? int'(reload_val) : exp_cnt - 1;
    endtask

    // toggle lines, settle, check count and (on a step) direction
    task automatic tog(input bit ta, input bit tb, input int d, input string req);
        logic dir_before;
        dir_before = dir_down;
        if (ta) line_a = ~line_a;
        if (tb) line_b = ~line_b;
        settle();
        model_step(d);
        chk(req, count, exp_cnt);
        if (d > 0)      chk({req, " R10 dir"}, dir_down, 0);
        else if (d < 0) chk({req, " R10 dir"}, dir_down, 1);
        else            chk({req, " R10 dir kept"}, dir_down, dir_before);
    endtask

    task automatic configure(input logic [3:0] m, input logic pa, input logic pb,
                             input logic la, input logic lb);
        @(negedge clk);
        en = 1'b0;
        mode = m; pol_a = pa; pol_b = pb;
        line_a = la; line_b = lb;
        repeat (5) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 dir", dir_down, 0);
        chk("R1 update", update, 0);
    endtask

    task automatic t_split_x2();
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(1, 0, +1, "R2 A fall");
        tog(1, 0, +1, "R2 A rise");
        tog(0, 1, -1, "R2 B fall");
        tog(0, 1, -1, "R2 B rise");
        configure(4'b1100, 1'b1, 1'b1, 1'b0, 1'b0);
        tog(1, 0, +1, "R2 pol1 A rise");
        tog(1, 0, +1, "R2 pol1 A fall");
    endtask

    task automatic t_split_x1();
        configure(4'b1101, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(1, 0, +1, "R3 pol0 A fall counts");
        tog(1, 0,  0, "R3 pol0 A rise ignored");
        tog(0, 1, -1, "R3 pol0 B fall counts");
        tog(0, 1,  0, "R3 pol0 B rise ignored");
        configure(4'b1101, 1'b1, 1'b1, 1'b0, 1'b0);
        tog(1, 0, +1, "R3 pol1 A rise counts");
        tog(1, 0,  0, "R3 pol1 A fall ignored");
        tog(0, 1, -1, "R3 pol1 B rise counts");
        tog(0, 1,  0, "R3 pol1 B fall ignored");
    endtask

    task automatic t_sdir_x2();
        configure(4'b1010, 1'b0, 1'b0, 1'b1, 1'b0);
        tog(0, 1, +1, "R4 A high B rise up");
        tog(0, 1, +1, "R4 A high B fall up");
        tog(1, 0,  0, "R4 A change no step");
        tog(0, 1, -1, "R4 A low B rise down");
        tog(0, 1, -1, "R4 A low B fall down");
    endtask

    task automatic t_sdir_x1();
        configure(4'b1011, 1'b0, 1'b1, 1'b1, 1'b0);
        tog(0, 1, +1, "R5 pol1 B rise counts");
        tog(0, 1,  0, "R5 pol1 B fall ignored");
        configure(4'b1011, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(0, 1, +1, "R5 pol0 B fall counts");
        tog(0, 1,  0, "R5 pol0 B rise ignored");
    endtask

    task automatic t_dir_pol();
        configure(4'b1010, 1'b1, 1'b0, 1'b1, 1'b0);
        tog(0, 1, -1, "R6 pol_a1 A high down");
        tog(1, 0,  0, "R6 A change no step");
        tog(0, 1, +1, "R6 pol_a1 A low up");
    endtask

    task automatic t_coincident();
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(1, 1, 0, "R7 both fall hold");
        tog(1, 1, 0, "R7 both rise hold");
        configure(4'b1101, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(1, 1, 0, "R7 x1 both fall hold");
    endtask

    task automatic t_wrap_up();
        int u0;
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        while (exp_cnt != int'(reload_val)) tog(1, 0, +1, "R8 climb");
        u0 = upd_seen;
        tog(1, 0, +1, "R8 wrap to zero");
        chk("R8 count zero", count, 0);
        chk("R8 one update", upd_seen - u0, 1);
    endtask

    task automatic t_wrap_down();
        int u0;
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        u0 = upd_seen;
        tog(0, 1, -1, "R9 wrap to reload");
        chk("R9 count reload", count, reload_val);
        chk("R9 one update", upd_seen - u0, 1);
        u0 = upd_seen;
        tog(0, 1, -1, "R9 next down");
        chk("R9 no update", upd_seen - u0, 0);
    endtask

    task automatic t_cfg_locked();
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        mode = 4'b0000; pol_a = 1'b1; pol_b = 1'b1;
        tog(1, 0, +1, "R11 mode change ignored");
        tog(1, 0, +1, "R11 pol change ignored");
    endtask

    task automatic t_bad_mode();
        configure(4'b0111, 1'b0, 1'b0, 1'b1, 1'b1);
        tog(1, 0, 0, "R12 undefined A");
        tog(0, 1, 0, "R12 undefined B");
    endtask

    task automatic t_disabled();
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        tog(1, 0, 0, "R13 disabled A");
        tog(0, 1, 0, "R13 disabled B");
    endtask

    task automatic t_latency();
        configure(4'b1100, 1'b0, 1'b0, 1'b1, 1'b1);
        line_a = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R14 not yet", count, exp_cnt);
        @(posedge clk);
        @(negedge clk);
        model_step(+1);
        chk("R14 third edge", count, exp_cnt);
        settle();
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_split_x2();
        t_split_x1();
        t_sdir_x2();
        t_sdir_x1();
        t_dir_pol();
        t_coincident();
        t_wrap_up();
        t_wrap_down();
        t_cfg_locked();
        t_bad_mode();
        t_disabled();
        t_latency();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule